// File: doc/BRIEF.md
# I2C Bus Status and Mode Tracker

This block keeps the status and mode state of a combined master/slave I2C controller. It watches the SDA and SCL lines through a synchronizer and detects START and STOP conditions to maintain a bus-busy flag. It holds the master/transmit mode pair, an arbitration-lost flag, address-match and general-call flags, the last received bit and an active-low interrupt-pending bit. All of these are packed into one 8-bit status word that a CPU-side port can read and partly write.

The byte shift path, clock generation and baud logic lie outside the block. They reach it only as strobes: `byte_done` marks a finished byte, `addr_byte` marks that byte as an address, and `bit_in` carries its final bit. A guard refuses a local START request once another master has claimed the bus. It suppresses the grant, the bit-counter clear and the SCL drive, and it drops the master bit. The master bit also clears itself on a STOP, and at the end of a byte in which arbitration was lost.

Top module: `i2c_stat_track`

## Requirements
- R1: After reset, `status` reads 8'h08: only bit 3 (interrupt-pending, active low) is 1. `start_go`, `cnt_clr` and `scl_drive_en` are 0.
- R2: A status write (`reg_wr`=1, `reg_sel`=0) loads the mode pair from `wr_data[1]` (master bit) and `wr_data[0]` (transmit bit). The mode pair {bit1, bit0} encodes 00 as slave receive, 01 as slave transmit, 10 as master receive and 11 as master transmit.
- R3: A START (SDA falls while SCL is high) sets the busy flag `status[2]`, and a STOP (SDA rises while SCL is high) clears it. Each takes effect within 3 clock edges of the line change. SDA edges while SCL is low change nothing.
- R4: A STOP clears the master bit `status[1]`, the address-match flag `status[5]` and the general-call flag `status[4]`.
- R5: An `arb_lost` strobe sets the arbitration-lost flag `status[6]`, and the next START clears it. A `byte_done` while that flag is set clears the master bit.
- R6: A `start_req` while busy is 1 gives `start_go`=0 and `cnt_clr`=0 in the same cycle, a cleared master bit on the next edge, and `scl_drive_en`=0. A `start_req` while the bus is free gives `start_go`=1 and `cnt_clr`=1 in the same cycle. It then gives `scl_drive_en`=1 from the next edge while the master bit is set, until a STOP.
- R7: `byte_done` drives `status[3]` to 0 on the next edge; this wins over a simultaneous write. A data-register write (`reg_wr`=1, `reg_sel`=1) sets it to 1, and a status write loads it from `wr_data[3]`.
- R8: Status writes do not change bits 7..4 or bit 2.
- R9: On `byte_done` with `addr_byte`, `status[5]` loads (`rx_byte[7:1]` == `own_addr`) and `status[4]` loads (`rx_byte` == 8'h00).
- R10: Every `byte_done` loads `bit_in` into `status[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| byte_done | input | 1 | Strobe: one byte transfer finished |
| addr_byte | input | 1 | Qualifies byte_done as an address byte |
| rx_byte | input | ADDR_W+1 | Received byte (address in the upper bits, R/W in bit 0) |
| bit_in | input | 1 | Last bit of the finished byte |
| arb_lost | input | 1 | Strobe: arbitration lost during the current byte |
| start_req | input | 1 | Local request to generate a START |
| own_addr | input | ADDR_W | Programmed slave address |
| reg_wr | input | 1 | CPU write strobe |
| reg_sel | input | 1 | Write target: 0 status word, 1 data register |
| wr_data | input | 8 | CPU write data |
| status | output | 8 | Status word |
| start_go | output | 1 | Local START granted |
| cnt_clr | output | 1 | Bit-counter clear for a granted START |
| scl_drive_en | output | 1 | Local SCL drive allowed |

## Verification
Strobes and CPU writes land in `status` on the first edge after they are applied. The bench therefore drives at a falling edge and reads the word at the next falling edge. Line changes pass two synchronizer flops and the condition register, so the busy flag and the flags cleared by START or STOP are due on the third edge; the bench waits four full cycles before sampling them. `start_go` and `cnt_clr` are combinational from the request, so they are read 1 ns after the request is driven. `scl_drive_en` and the master-bit clear caused by a refused request are read one cycle later.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int DATA_W = 8;

    // Status word, most significant field first
    typedef struct packed {
        logic last_bit;    // [7]
        logic arb_lost;    // [6]
        logic addr_match;  // [5]
        logic gen_call;    // [4]
        logic irq_n;       // [3] active low
        logic busy;        // [2]
        logic mst;         // [1]
        logic trx;         // [0]
    } stat_t;

    localparam stat_t STAT_RESET = '{irq_n: 1'b1, default: 1'b0};

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_DATA   = 1'b1;

    localparam logic [DATA_W-1:0] GEN_CALL_BYTE = '0;

    function automatic logic addr_hit(input logic [DATA_W-1:0] rx,
                                      input logic [DATA_W-2:0] own);
        return rx[DATA_W-1:1] == own;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[i] <= RST_VAL;
            end else if (i == 0) begin
                chain[i] <= din;
            end else begin
                chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
    input  logic clk,
    input  logic rst,
    input  logic sda_s,
    input  logic scl_s,
    output logic start_det,
    output logic stop_det
);
    logic sda_d, scl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_s;
            scl_d <= scl_s;
        end
    end

    assign start_det = scl_s & scl_d &  sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/i2c_start_guard.sv
module i2c_start_guard (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic busy,
    input  logic mst,
    input  logic stop_det,
    output logic start_go,
    output logic cnt_clr,
    output logic start_blocked,
    output logic scl_drive_en
);
    logic own_q;

    assign start_go      = start_req & ~busy;
    assign start_blocked = start_req &  busy;
    assign cnt_clr       = start_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= 1'b0;
        end else if (stop_det || !mst) begin
            own_q <= 1'b0;
        end else if (start_go) begin
            own_q <= 1'b1;
        end
    end

    assign scl_drive_en = own_q & mst;
endmodule

// File: rtl/i2c_stat_regs.sv
module i2c_stat_regs
    import i2c_stat_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_done,
    input  logic              addr_byte,
    input  logic [ADDR_W:0]   rx_byte,
    input  logic              bit_in,
    input  logic              arb_lost,
    input  logic              start_blocked,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output stat_t             stat
);
    stat_t q, d;
    stat_t w;
    logic  unused_wr_bits;

    assign w = stat_t'(wr_data);
    assign unused_wr_bits = ^{w.last_bit, w.arb_lost, w.addr_match, w.gen_call, w.busy};

    always_comb begin
        d = q;
        if (start_det)     d.busy = 1'b1;
        else if (stop_det) d.busy = 1'b0;

        if (arb_lost)       d.arb_lost = 1'b1;
        else if (start_det) d.arb_lost = 1'b0;

        if (reg_wr && reg_sel == SEL_STATUS) begin
            d.mst   = w.mst;
            d.trx   = w.trx;
            d.irq_n = w.irq_n;
        end
        if (reg_wr && reg_sel == SEL_DATA) d.irq_n = 1'b1;

        if (byte_done) begin
            d.irq_n    = 1'b0;
            d.last_bit = bit_in;
            if (addr_byte) begin
                d.addr_match = (ADDR_W + 1 == DATA_W) ?
                               addr_hit(DATA_W'(rx_byte), DATA_W'(own_addr) & {(DATA_W-1){1'b1}}) :
                               (rx_byte[ADDR_W:1] == own_addr);
                d.gen_call   = (rx_byte == '0);
            end
            if (q.arb_lost || arb_lost) d.mst = 1'b0;
        end

        if (stop_det) begin
            d.mst        = 1'b0;
            d.addr_match = 1'b0;
            d.gen_call   = 1'b0;
        end
        if (start_blocked) d.mst = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= STAT_RESET;
        else     q <= d;
    end

    assign stat = q;
endmodule

// File: rtl/i2c_stat_track.sv
module i2c_stat_track
    import i2c_stat_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              byte_done,
    input  logic              addr_byte,
    input  logic [ADDR_W:0]   rx_byte,
    input  logic              bit_in,
    input  logic              arb_lost,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        wr_data,
    output logic [7:0]        status,
    output logic              start_go,
    output logic              cnt_clr,
    output logic              scl_drive_en
);
    logic  sda_s, scl_s;
    logic  start_det, stop_det, start_blocked;
    stat_t stat;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst(rst), .din(sda_in), .dout(sda_s));
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s));

    i2c_cond_det u_det (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_s(scl_s),
        .start_det(start_det), .stop_det(stop_det));

    i2c_start_guard u_guard (
        .clk(clk), .rst(rst), .start_req(start_req), .busy(stat.busy),
        .mst(stat.mst), .stop_det(stop_det), .start_go(start_go),
        .cnt_clr(cnt_clr), .start_blocked(start_blocked),
        .scl_drive_en(scl_drive_en));

    i2c_stat_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
        .byte_done(byte_done), .addr_byte(addr_byte), .rx_byte(rx_byte),
        .bit_in(bit_in), .arb_lost(arb_lost), .start_blocked(start_blocked),
        .own_addr(own_addr), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .wr_data(wr_data), .stat(stat));

    assign status = stat;
endmodule

// File: rtl/i2c_stat_track_chk.sv
module i2c_stat_track_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] status,
    input logic       start_det,
    input logic       stop_det,
    input logic       byte_done,
    input logic       arb_lost,
    input logic       start_req,
    input logic       start_go,
    input logic       cnt_clr,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic       scl_drive_en
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (status == 8'h08 && !scl_drive_en));

    p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (rst)
        start_det |=> status[2]);

    p_stop_clears_r4: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!status[1] && !status[5] && !status[4] && !status[2]));

    p_arb_byte_drops_mst_r5: assert property (@(posedge clk) disable iff (rst)
        (byte_done && (status[6] || arb_lost)) |=> !status[1]);

    p_blocked_start_r6: assert property (@(posedge clk) disable iff (rst)
        (start_req && status[2]) |-> (!start_go && !cnt_clr));

    p_blocked_drops_mst_r6: assert property (@(posedge clk) disable iff (rst)
        (start_req && status[2]) |=> (!status[1] && !scl_drive_en));

    p_byte_irq_low_r7: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !status[3]);

    p_ro_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel && !byte_done && !arb_lost && !start_det && !stop_det)
        |=> (status[7:4] == $past(status[7:4]) && status[2] == $past(status[2])));
endmodule

bind i2c_stat_track i2c_stat_track_chk u_chk (
    .clk(clk), .rst(rst), .status(status), .start_det(start_det),
    .stop_det(stop_det), .byte_done(byte_done), .arb_lost(arb_lost),
    .start_req(start_req), .start_go(start_go), .cnt_clr(cnt_clr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .scl_drive_en(scl_drive_en));

// File: tb/i2c_stat_track_bench.sv
`timescale 1ns/1ps
module i2c_stat_track_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sda_in = 1'b1, scl_in = 1'b1;
    logic       byte_done = 1'b0, addr_byte = 1'b0, bit_in = 1'b0, arb_lost = 1'b0;
    logic       start_req = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] rx_byte = '0, wr_data = '0;
    logic [6:0] own_addr = 7'h2A;
    logic [7:0] status;
    logic       start_go, cnt_clr, scl_drive_en;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_stat_track u_i2c_stat_track (
        .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
        .byte_done(byte_done), .addr_byte(addr_byte), .rx_byte(rx_byte),
        .bit_in(bit_in), .arb_lost(arb_lost), .start_req(start_req),
        .own_addr(own_addr), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .wr_data(wr_data), .status(status), .start_go(start_go),
        .cnt_clr(cnt_clr), .scl_drive_en(scl_drive_en));

    // {op nibble, data byte, bit_in nibble, expected status byte}
    // op: 0 status write, 1 data write, 2 address byte, 3 data byte, 4 arbitration lost
    localparam int NV = 16;
    localparam logic [23:0] VEC [NV] = '{
        24'h00B00B, 24'h00A00A, 24'h009009, 24'h0FC008,
        24'h254020, 24'h100028, 24'h200010, 24'h008018,
        24'h300190, 24'h300010, 24'h00A01A, 24'h40005A,
        24'h3001D0, 24'h00B0DB, 24'h300051, 24'h2551E1
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] v);
        reg_wr = 1'b1; reg_sel = sel; wr_data = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        cyc(50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 status", status, 8'h08);
        chk("R1 outputs", {5'b0, start_go, cnt_clr, scl_drive_en}, 8'h00);

        // Table walk: R2 modes, R5 arbitration, R7 irq, R8 read-only, R9 address, R10 last bit
        for (int v = 0; v < NV; v++) begin
            logic [3:0] op;
            op = VEC[v][23:20];
            case (op)
                4'h0: begin reg_wr = 1'b1; reg_sel = 1'b0; wr_data = VEC[v][19:12]; end
                4'h1: begin reg_wr = 1'b1; reg_sel = 1'b1; wr_data = VEC[v][19:12]; end
                4'h2: begin byte_done = 1'b1; addr_byte = 1'b1; rx_byte = VEC[v][19:12]; bit_in = VEC[v][8]; end
                4'h3: begin byte_done = 1'b1; rx_byte = VEC[v][19:12]; bit_in = VEC[v][8]; end
                default: arb_lost = 1'b1;
            endcase
            @(negedge clk);
            reg_wr = 1'b0; byte_done = 1'b0; addr_byte = 1'b0; arb_lost = 1'b0;
            chk($sformatf("R2/R5/R7/R8/R9/R10 vector %0d", v), status, VEC[v][7:0]);
        end

        // R3 START sets busy, R5 START clears arbitration-lost
        sda_in = 1'b0; cyc(4);
        chk("R3 busy after START", {7'b0, status[2]}, 8'h01);
        chk("R5 arb flag cleared by START", {7'b0, status[6]}, 8'h00);

        // R6 refused START while busy
        wr(1'b0, 8'h0A);
        chk("R2 master receive", {6'b0, status[1:0]}, 8'h02);
        start_req = 1'b1; #1;
        chk("R6 blocked grant", {6'b0, start_go, cnt_clr}, 8'h00);
        @(negedge clk); start_req = 1'b0;
        chk("R6 blocked mst/scl", {6'b0, status[1], scl_drive_en}, 8'h00);

        // R4 STOP clears master, address and general-call flags
        wr(1'b0, 8'h0A);
        sda_in = 1'b1; cyc(4);
        chk("R3 busy after STOP", {7'b0, status[2]}, 8'h00);
        chk("R4 STOP clears", {5'b0, status[5], status[4], status[1]}, 8'h00);

        // R3 SDA edges while SCL low are ignored
        scl_in = 1'b0; cyc(3); sda_in = 1'b0; cyc(3); sda_in = 1'b1; cyc(3);
        scl_in = 1'b1; cyc(4);
        chk("R3 no event with SCL low", {7'b0, status[2]}, 8'h00);

        // R6 granted START on a free bus
        wr(1'b0, 8'h0B);
        start_req = 1'b1; #1;
        chk("R6 grant", {6'b0, start_go, cnt_clr}, 8'h03);
        @(negedge clk); start_req = 1'b0;
        chk("R6 scl drive on", {7'b0, scl_drive_en}, 8'h01);
        sda_in = 1'b0; cyc(4);
        chk("R6 scl drive held", {7'b0, scl_drive_en}, 8'h01);
        sda_in = 1'b1; cyc(4);
        chk("R4/R6 STOP drops drive", {6'b0, status[1], scl_drive_en}, 8'h00);

        // R7 byte_done wins over a simultaneous data write
        reg_wr = 1'b1; reg_sel = 1'b1; byte_done = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; byte_done = 1'b0;
        chk("R7 byte beats write", {7'b0, status[3]}, 8'h00);
        chk("R10 last bit", {7'b0, status[7]}, 8'h01);
        wr(1'b1, 8'h00);
        chk("R7 data write releases", {7'b0, status[3]}, 8'h01);

        // R1 reset from a busy, mastered state
        wr(1'b0, 8'h03);
        sda_in = 1'b0; cyc(4);
        rst = 1'b1; cyc(2); rst = 1'b0; sda_in = 1'b1; cyc(1);
        chk("R1 reset again", status, 8'h08);

        finish_run();
    end
endmodule